// File: doc/BRIEF.md
# Base Address Register Decoder

This block holds the base address registers (BARs) of a bus target's configuration space. It also decodes incoming transaction addresses against them. Up to six BAR slots and one optional expansion ROM register are built from parameters. A slot index at or above the count parameter produces no logic. Slot 0 and slot 1 can be fused into a single 64-bit memory window. Each slot has a mask parameter that marks which of its bits software may write, and those same bits are used in the address compare.

Software sizes a window in three steps. It writes all ones to the slot, reads the value back, and sees the writable bits together with the fixed type bits in the low nibble. It then writes the chosen base. When the memory-space and I/O-space enables are set, each transaction address is compared against the stored bases. The result is a hit vector with one bit per slot, and bit 6 is the ROM. The hit vector is combinational from the address and the registered bases. Configuration reads come back through a registered data port.

Top module: `bar_decode_unit`

## Requirements
- R1: In the cycle that reset is high, every slot register and the ROM register are cleared. After reset the read port returns zero.
- R2: A write stores `cfg_wdata & writable` into the slot picked by `cfg_idx`. Index encoding: 0 to 5 select BAR slots, 6 selects the ROM register, and 7 reads zero and ignores writes. Writable bits are the slot mask without bits [3:0] for memory slots, or without bits [1:0] for I/O slots. So a write of all ones reads back as the window size.
- R3: The low bits of a read are fixed type bits. An I/O slot reads bit 0 as 1. The low half of a 64-bit pair reads bits [2:1] as 2'b10. A prefetchable memory slot reads bit 3 as 1.
- R4: A slot whose index is at or above the count parameter reads zero, keeps no written value and never hits.
- R5: A 32-bit memory slot hits when all of the following hold: the access is to memory space (`acc_io`=0), `mem_en` is 1, `acc_addr[63:32]` is zero, and the address equals the base on every writable bit.
- R6: An I/O slot hits when all of the following hold: `acc_io`=1, `io_en` is 1, the upper address half is zero, and the address equals the base on every writable bit.
- R7: When the 64-bit pair is selected, slot 1 is fully writable, has no type bits and never hits. Slot 0 hits on bit 0 only when the low half matches slot 0 and `acc_addr[63:32]` equals slot 1. An address with a zero upper half therefore hits only while slot 1 is zero.
- R8: The ROM register keeps its mask bits plus bit 0 as a decode enable. It hits on bit 6 when all of the following hold: the access is to memory space, `mem_en` is 1, bit 0 is set, the upper address half is zero, and the masked address matches.
- R9: With the ROM enable parameter off, index 6 reads zero, its mask is ignored and bit 6 never hits.
- R10: `cfg_rdata` shows the register selected by `cfg_idx` one clock after that index was presented. The value is the one held before any write in that same cycle.
- R11: The hit vector follows the current address and enables in the same cycle, and at most one bit is set when the programmed windows do not overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register index: 0-5 BAR slots, 6 ROM, 7 none |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| mem_en | input | 1 | Memory-space decode enable |
| io_en | input | 1 | I/O-space decode enable |
| acc_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| acc_addr | input | 64 | Transaction address; upper half zero for single-cycle addressing |
| hit | output | 7 | One-hot hit vector: bits 0-5 slots, bit 6 ROM |

## Verification
The at-most-one-hit property assumes that software never lets two enabled windows cover the same address. The bench meets this by keeping `mem_en` and `io_en` low while the registers are zero or holding the all-ones sizing pattern, and by programming disjoint bases before it raises them. The other properties assume nothing about the inputs, apart from the fact that reset is held for at least one clock at start-up. The stimulus walks addresses exactly on and just past window edges and toggles each enable, so that the reference model's hit vector is compared in every case.

// File: rtl/bar_pkg.sv
package bar_pkg;

  localparam int BAR_SLOTS = 6;
  localparam int HIT_W     = BAR_SLOTS + 1;
  localparam int ROM_BIT   = BAR_SLOTS;
  localparam int IDX_W     = 3;

  typedef enum logic [1:0] {
    SLOT_OFF  = 2'd0,
    SLOT_W32  = 2'd1,
    SLOT_LO64 = 2'd2,
    SLOT_HI64 = 2'd3
  } slot_kind_e;

  // Fixed read-only low bits of a slot.
  function automatic logic [31:0] type_bits(input bit is_io, input bit is64, input bit pref);
    logic [31:0] t;
    t = '0;
    if (is_io) begin
      t[0] = 1'b1;
    end else begin
      t[2:1] = is64 ? 2'b10 : 2'b00;
      t[3]   = pref;
    end
    return t;
  endfunction

  // Bits software may write (and that take part in the compare).
  function automatic logic [31:0] writable(input logic [31:0] mask, input bit is_io,
                                           input slot_kind_e kind);
    if (kind == SLOT_HI64) return 32'hFFFF_FFFF;
    if (is_io)             return mask & 32'hFFFF_FFFC;
    return mask & 32'hFFFF_FFF0;
  endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot #(
  parameter logic [31:0]         MASK  = 32'hFFF0_0000,
  parameter bit                  IS_IO = 1'b0,
  parameter bit                  PREF  = 1'b0,
  parameter bar_pkg::slot_kind_e KIND  = bar_pkg::SLOT_W32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        mem_en,
  input  logic        io_en,
  input  logic        acc_io,
  input  logic [31:0] addr_lo,
  output logic [31:0] base,
  output logic [31:0] rdata,
  output logic        lo_match
);
  import bar_pkg::*;

  localparam logic [31:0] WMASK = writable(MASK, IS_IO, KIND);
  localparam logic [31:0] TBITS = (KIND == SLOT_HI64) ? 32'h0
                                  : type_bits(IS_IO, KIND == SLOT_LO64, PREF);

  logic [31:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)     base_q <= '0;
    else if (we) base_q <= wdata & WMASK;
  end

  assign base  = base_q;
  assign rdata = base_q | TBITS;

  generate
    if (KIND == SLOT_HI64) begin : g_hi
      // Upper half of a pair: compared by the low slot, no own decode.
      assign lo_match = 1'b0;
    end else begin : g_dec
      logic space_ok;
      if (IS_IO) begin : g_io
        assign space_ok = acc_io && io_en;
      end else begin : g_mem
        assign space_ok = !acc_io && mem_en;
      end
      assign lo_match = space_ok && ((addr_lo & WMASK) == base_q);
    end
  endgenerate

endmodule

// File: rtl/rom_slot.sv
module rom_slot #(
  parameter logic [31:0] MASK   = 32'hFF00_0000,
  parameter bit          ENABLE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        mem_en,
  input  logic        acc_io,
  input  logic [63:0] addr,
  output logic [31:0] rdata,
  output logic        hit
);

  generate
    if (ENABLE) begin : g_rom
      localparam logic [31:0] CMASK = MASK & 32'hFFFF_F800;
      localparam logic [31:0] WMASK = CMASK | 32'h1;
      logic [31:0] rom_q;

      always_ff @(posedge clk) begin
        if (rst)     rom_q <= '0;
        else if (we) rom_q <= wdata & WMASK;
      end

      assign rdata = rom_q;
      assign hit   = rom_q[0] && mem_en && !acc_io && (addr[63:32] == 32'h0)
                     && ((addr[31:0] & CMASK) == (rom_q & CMASK));
    end else begin : g_none
      assign rdata = '0;
      assign hit   = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bar_decode_unit.sv
module bar_decode_unit #(
  parameter int                                BAR_CNT   = 1,
  parameter bit                                BAR0_IS64 = 1'b0,
  parameter logic [bar_pkg::BAR_SLOTS*32-1:0]  BAR_MASKS = {bar_pkg::BAR_SLOTS{32'hFFF0_0000}},
  parameter logic [bar_pkg::BAR_SLOTS-1:0]     BAR_IO    = '0,
  parameter logic [bar_pkg::BAR_SLOTS-1:0]     BAR_PREF  = '0,
  parameter bit                                ROM_EN    = 1'b0,
  parameter logic [31:0]                       ROM_MASK  = 32'hFF00_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_en,
  input  logic        io_en,
  input  logic        acc_io,
  input  logic [63:0] acc_addr,
  output logic [6:0]  hit
);
  import bar_pkg::*;

  localparam int SLOTS = BAR_SLOTS;

  logic [31:0] base_q  [SLOTS];
  logic [31:0] slot_rd [SLOTS];
  logic        lo_m    [SLOTS];
  logic [31:0] rom_rd;
  logic        rom_hit;
  logic        hi_zero;
  logic [31:0] rd_mux;

  assign hi_zero = (acc_addr[63:32] == 32'h0);

  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      localparam slot_kind_e KIND =
        (k >= BAR_CNT)              ? SLOT_OFF  :
        (BAR0_IS64 && (k == 0))     ? SLOT_LO64 :
        (BAR0_IS64 && (k == 1))     ? SLOT_HI64 : SLOT_W32;

      if (KIND == SLOT_OFF) begin : g_off
        assign base_q[k]  = '0;
        assign slot_rd[k] = '0;
        assign lo_m[k]    = 1'b0;
        assign hit[k]     = 1'b0;
      end else begin : g_on
        bar_slot #(
          .MASK  (BAR_MASKS[k*32 +: 32]),
          .IS_IO (BAR_IO[k] && (KIND == SLOT_W32)),
          .PREF  (BAR_PREF[k]),
          .KIND  (KIND)
        ) u_slot (
          .clk      (clk),
          .rst      (rst),
          .we       (cfg_we && (cfg_idx == IDX_W'(k))),
          .wdata    (cfg_wdata),
          .mem_en   (mem_en),
          .io_en    (io_en),
          .acc_io   (acc_io),
          .addr_lo  (acc_addr[31:0]),
          .base     (base_q[k]),
          .rdata    (slot_rd[k]),
          .lo_match (lo_m[k])
        );
        if (KIND == SLOT_LO64) begin : g_pair
          assign hit[k] = lo_m[k] && (acc_addr[63:32] == base_q[1]);
        end else begin : g_flat
          assign hit[k] = lo_m[k] && hi_zero;
        end
      end
    end
  endgenerate

  rom_slot #(
    .MASK   (ROM_MASK),
    .ENABLE (ROM_EN)
  ) u_rom (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we && (cfg_idx == IDX_W'(ROM_BIT))),
    .wdata  (cfg_wdata),
    .mem_en (mem_en),
    .acc_io (acc_io),
    .addr   (acc_addr),
    .rdata  (rom_rd),
    .hit    (rom_hit)
  );

  assign hit[ROM_BIT] = rom_hit;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (cfg_idx == IDX_W'(k)) rd_mux = slot_rd[k];
    end
    if (cfg_idx == IDX_W'(ROM_BIT)) rd_mux = rom_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end

endmodule

// File: rtl/bar_decode_chk.sv
module bar_decode_chk #(
  parameter int BAR_CNT   = 1,
  parameter bit BAR0_IS64 = 1'b0,
  parameter bit ROM_EN    = 1'b0
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_rdata,
  input logic        mem_en,
  input logic        io_en,
  input logic        acc_io,
  input logic [6:0]  hit
);

  function automatic logic [5:0] off_slots();
    logic [5:0] m;
    m = '0;
    for (int k = 0; k < 6; k++) if (k >= BAR_CNT) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [5:0] OFF_MASK = off_slots();

  // R1: the read port is cleared after a reset cycle
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (cfg_rdata == 32'h0));

  // R4: slots past the count never hit
  p_unused_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ((hit[5:0] & OFF_MASK) == 6'h0));

  // R5: no hit on a memory access with memory decode disabled
  p_mem_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (!acc_io && !mem_en) |-> (hit == 7'h0));

  // R6: no hit on an I/O access with I/O decode disabled
  p_io_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_io && !io_en) |-> (hit == 7'h0));

  // R7: upper half of a 64-bit pair never hits on its own
  p_pair_hi_r7: assert property (@(posedge clk) disable iff (rst)
    BAR0_IS64 |-> !hit[1]);

  // R8: the ROM decodes memory space only
  p_rom_mem_only_r8: assert property (@(posedge clk) disable iff (rst)
    acc_io |-> !hit[6]);

  // R9: a ROM left out by parameter never hits
  p_rom_off_r9: assert property (@(posedge clk) disable iff (rst)
    !ROM_EN |-> !hit[6]);

  // R11: at most one window claims an access
  p_single_hit_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

endmodule

bind bar_decode_unit bar_decode_chk #(
  .BAR_CNT   (BAR_CNT),
  .BAR0_IS64 (BAR0_IS64),
  .ROM_EN    (ROM_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_rdata (cfg_rdata),
  .mem_en    (mem_en),
  .io_en     (io_en),
  .acc_io    (acc_io),
  .hit       (hit)
);

// File: tb/bar_decode_unit_test.sv
module bar_decode_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_en = 1'b0;
  logic        io_en = 1'b0;
  logic        acc_io = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [31:0] cfg_rdata, rd_b;
  logic [6:0]  hit, hit_b;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    live     = 1'b0;

  always #2 clk = ~clk;

  // slot 0/1 = 64-bit prefetchable pair, slot 2 = I/O, slot 3 = 32-bit memory, 4 and 5 off
  bar_decode_unit #(
    .BAR_CNT   (4),
    .BAR0_IS64 (1'b1),
    .BAR_MASKS ({32'hFFF0_0000, 32'hFFF0_0000, 32'hFFF0_0000,
                 32'hFFFF_FF00, 32'hFFF0_0000, 32'hFFF0_0000}),
    .BAR_IO    (6'b000100),
    .BAR_PREF  (6'b000001),
    .ROM_EN    (1'b1),
    .ROM_MASK  (32'hFF00_0000)
  ) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_en(mem_en), .io_en(io_en), .acc_io(acc_io),
    .acc_addr(acc_addr), .hit(hit)
  );

  // defaults: one 32-bit memory slot, no ROM
  bar_decode_unit uut_b (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_b), .mem_en(mem_en), .io_en(io_en), .acc_io(acc_io),
    .acc_addr(acc_addr), .hit(hit_b)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_reg [8];
  logic [31:0] m_rd;
  logic [31:0] mb_reg0;
  logic [31:0] mb_rd;

  function automatic logic [31:0] wr_mask(input int i);
    case (i)
      0: return 32'hFFF0_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'hFFFF_FF00;
      3: return 32'hFFF0_0000;
      6: return 32'hFF00_0001;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fixed_bits(input int i);
    if (i == 0) return 32'h0000_000C;
    if (i == 2) return 32'h0000_0001;
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_read(input int i);
    return m_reg[i] | ((m_reg[i] != 0 || wr_mask(i) != 0) ? fixed_bits(i) : 32'h0);
  endfunction

  function automatic logic [6:0] model_hit();
    logic [6:0] h;
    logic [31:0] lo, hi;
    lo = acc_addr[31:0];
    hi = acc_addr[63:32];
    h = '0;
    if (!acc_io && mem_en) begin
      if ((lo & 32'hFFF0_0000) == m_reg[0] && hi == m_reg[1]) h[0] = 1'b1;
      if (hi == 0 && (lo & 32'hFFF0_0000) == m_reg[3])        h[3] = 1'b1;
      if (hi == 0 && m_reg[6][0] && (lo & 32'hFF00_0000) == (m_reg[6] & 32'hFF00_0000))
        h[6] = 1'b1;
    end
    if (acc_io && io_en && hi == 0 && (lo & 32'hFFFF_FF00) == m_reg[2]) h[2] = 1'b1;
    return h;
  endfunction

  function automatic logic [6:0] model_hit_b();
    if (!acc_io && mem_en && acc_addr[63:32] == 0 &&
        (acc_addr[31:0] & 32'hFFF0_0000) == mb_reg0) return 7'h01;
    return 7'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m_reg[i] <= '0;
      m_rd    <= '0;
      mb_reg0 <= '0;
      mb_rd   <= '0;
    end else begin
      m_rd  <= model_read(int'(cfg_idx));
      mb_rd <= (cfg_idx == 0) ? mb_reg0 : 32'h0;
      if (cfg_we) begin
        m_reg[cfg_idx] <= cfg_wdata & wr_mask(int'(cfg_idx));
        if (cfg_idx == 0) mb_reg0 <= cfg_wdata & 32'hFFF0_0000;
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      check(hit == model_hit(), "hit", 64'(hit), 64'(model_hit()));
      check(cfg_rdata == m_rd, "rdata", 64'(cfg_rdata), 64'(m_rd));
      check(hit_b == model_hit_b(), "hit_b", 64'(hit_b), 64'(model_hit_b()));
      check(rd_b == mb_rd, "rdata_b", 64'(rd_b), 64'(mb_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit we, input logic [2:0] idx, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = we; cfg_idx = idx; cfg_wdata = d;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    step(1'b1, idx, d);
    step(1'b0, idx, 32'h0);
  endtask

  task automatic rd_expect(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    step(1'b0, idx, 32'h0);
    @(posedge clk); @(negedge clk);
    cur_req = tag;
    check(cfg_rdata == exp, "readback", 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic acc(input bit io, input logic [63:0] a, input logic [6:0] exp, input string tag);
    @(posedge clk); #1;
    acc_io = io; acc_addr = a;
    @(negedge clk);
    cur_req = tag;
    check(hit == exp, "hit explicit", 64'(hit), 64'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    live = 1'b1;
    rst  = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check(cfg_rdata == 0 && hit == 0, "reset state", 64'(cfg_rdata), 64'h0);
    rd_expect(3'd3, 32'h0, "R1");
    rd_expect(3'd6, 32'h0, "R1");

    // sizing: all ones
    cur_req = "R2";
    for (int i = 0; i < 8; i++) wr(3'(i), 32'hFFFF_FFFF);
    rd_expect(3'd0, 32'hFFF0_000C, "R3");
    rd_expect(3'd1, 32'hFFFF_FFFF, "R7");
    rd_expect(3'd2, 32'hFFFF_FF01, "R3");
    rd_expect(3'd3, 32'hFFF0_0000, "R2");
    rd_expect(3'd6, 32'hFF00_0001, "R8");
    rd_expect(3'd4, 32'h0, "R4");
    rd_expect(3'd5, 32'h0, "R4");
    rd_expect(3'd7, 32'h0, "R2");
    cur_req = "R9";
    check(rd_b == 32'h0, "rom off readback", 64'(rd_b), 64'h0);

    // R10: read of a slot in the cycle it is written shows the old value
    step(1'b1, 3'd3, 32'h4000_0000);
    @(posedge clk); @(negedge clk);
    cur_req = "R10";
    check(cfg_rdata == 32'hFFF0_0000, "read during write", 64'(cfg_rdata), 64'hFFF0_0000);
    step(1'b0, 3'd3, 32'h0);

    // program disjoint bases
    cur_req = "R2";
    wr(3'd0, 32'h8010_0000);
    wr(3'd1, 32'h0000_0001);
    wr(3'd2, 32'h0000_1200);
    wr(3'd6, 32'h2000_0001);
    rd_expect(3'd2, 32'h0000_1201, "R2");
    @(posedge clk); #1;
    mem_en = 1'b1; io_en = 1'b1;

    acc(1'b0, 64'h0000_0000_4000_0010, 7'h08, "R5");
    acc(1'b0, 64'h0000_0000_400F_FFFF, 7'h08, "R5");
    acc(1'b0, 64'h0000_0000_4010_0000, 7'h00, "R5");
    acc(1'b0, 64'h0000_0001_4000_0010, 7'h00, "R5");
    acc(1'b0, 64'h0000_0001_8010_0004, 7'h01, "R7");
    acc(1'b0, 64'h0000_0000_8010_0004, 7'h00, "R7");
    cur_req = "R4";
    check(hit_b == 7'h01, "default slot hit", 64'(hit_b), 64'h01);
    acc(1'b1, 64'h0000_0000_0000_1234, 7'h04, "R6");
    acc(1'b1, 64'h0000_0000_0000_1300, 7'h00, "R6");
    acc(1'b1, 64'h0000_0000_4000_0010, 7'h00, "R6");
    acc(1'b0, 64'h0000_0000_0000_1234, 7'h00, "R6");
    @(posedge clk); #1; io_en = 1'b0;
    acc(1'b1, 64'h0000_0000_0000_1234, 7'h00, "R6");
    acc(1'b0, 64'h0000_0000_20FF_FFFF, 7'h40, "R8");
    acc(1'b0, 64'h0000_0000_2100_0000, 7'h00, "R8");
    cur_req = "R9";
    check(hit_b == 7'h00, "rom off no hit", 64'(hit_b), 64'h0);

    wr(3'd6, 32'h2000_0000);
    acc(1'b0, 64'h0000_0000_2000_0040, 7'h00, "R8");

    @(posedge clk); #1; mem_en = 1'b0;
    acc(1'b0, 64'h0000_0000_4000_0010, 7'h00, "R5");
    @(posedge clk); #1; mem_en = 1'b1;
    acc(1'b0, 64'h0000_0000_4000_0010, 7'h08, "R11");

    // collapse the pair onto single-cycle addressing
    wr(3'd1, 32'h0);
    acc(1'b0, 64'h0000_0000_8010_0000, 7'h01, "R7");
    acc(1'b0, 64'h0000_0000_801F_FFFF, 7'h01, "R11");

    repeat (3) @(posedge clk);
    @(negedge clk);
    live = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule